// File: doc/BRIEF.md
# Reference Divider, Phase-Frequency Detector and Test Override

This block belongs to the digital side of a frequency synthesizer. Its clock is the reference clock. A programmable divider turns that clock into a comparison tick. The divider ratio comes from a 5-bit code and is not a plain binary count. An upper pair of code bits picks a base of 2, 5, 6 or 7, and the lower three bits pick a power-of-two multiplier. A synchronous tri-state phase-frequency detector then compares each comparison tick with a one-cycle pulse from the divided local oscillator. It drives pump-up and pump-down commands, and a lock detector watches how wide those commands are.

Test control can take over three things: the pump commands, the lock flag and the four switching-port levels. Port 0 can also carry either the half-rate divided oscillator signal or the comparison tick, so the divider can be observed from outside. The 2-bit pump-current code has no meaning here and goes straight through to the analog side.

Top module: `refcomp_pfd`

## Requirements
- R1: With ratioCode[4:3] = 00, the comparison tick repeats every 2 << ratioCode[2:0] clocks (codes 00000..00111 give 2 up to 256).
- R2: With ratioCode[4:3] = 01, 10 or 11 and ratioCode[2:0] = 001..111, the tick repeats every (4 + ratioCode[4:3]) << (ratioCode[2:0] - 1) clocks. This gives base 5, 6 or 7 times 1 up to 64.
- R3: Codes 01000, 10000 and 11000 are illegal. For these, the tick repeats every 2 clocks and ratioErr is 1. For every legal code, ratioErr is 0.
- R4: In normal operation, pumpUp goes high the clock after a comparison tick and pumpDn goes high the clock after an fpdPulse. Once both are set, both clear on the same edge, so the two are never high together. Both are 0 in reset.
- R5: lockFlag goes to 1 after 8 consecutive comparison periods in which every pumpUp and pumpDn pulse lasted fewer than 2 clocks. It returns to 0 at the comparison tick that closes the first period breaking that rule. It is 0 in reset.
- R6: When testEn = 0, or when testEn = 1 with testSel = 000, the pump and lock outputs behave as in R4 and R5.
- R7: With testEn = 1, the override depends on testSel[1:0]. A value of 01 gives pumpDn = 1, pumpUp = 0 and lockFlag = 0. A value of 10 gives pumpUp = 1, pumpDn = 0 and lockFlag = 0. A value of 11 gives both pump outputs 0 and lockFlag = 1. While any of these holds, the lock history is cleared, so lockFlag reads 0 right after the override is left.
- R8: With testEn = 0, portOut equals portProg (1 = on). With testEn = 1, portOut[3:1] = testSel[2:0], and portOut[0] depends on testSel. For testSel[2] = 0, portOut[0] is portProg[0]. For testSel = 100, it is fpdHalf. For 101, 110 and 111, it is the one-clock comparison tick.
- R9: pumpCurrent always equals pumpSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| fpdPulse | input | 1 | One-clock pulse from the divided local oscillator |
| fpdHalf | input | 1 | Divided oscillator at half rate, routed to port 0 in test |
| ratioCode | input | 5 | Reference ratio select |
| pumpSel | input | 2 | Pump current code |
| testEn | input | 1 | Test override enable |
| testSel | input | 3 | Test mode select |
| portProg | input | 4 | Programmed switching-port levels |
| pumpUp | output | 1 | Charge pump source command |
| pumpDn | output | 1 | Charge pump sink command |
| lockFlag | output | 1 | Phase lock indication |
| portOut | output | 4 | Switching-port levels |
| pumpCurrent | output | 2 | Pump current code to the analog side |
| ratioErr | output | 1 | Illegal ratio code indication |

## Verification
The hardest situation to reach is a controlled phase offset between the oscillator pulse and the comparison tick, because the tick is internal. The stimulus closes the loop. It waits until pumpUp is seen, then sends fpdPulse after a chosen lag. This sets the width of each pump pulse exactly, for lock builds, lock losses and a pump-down lead. The divider ratios are measured through port 0 in a test mode that exposes the tick.

// File: rtl/refcomp_pkg.sv
package refcomp_pkg;
  localparam int CODE_W  = 5;
  localparam int MAX_RATIO = 7 << 6;
  localparam int RATIO_W = $clog2(MAX_RATIO + 1);

  typedef struct packed {
    logic [RATIO_W-1:0] limit;
    logic               clearPump;
  } dpCtrl_t;

  typedef struct packed {
    logic compTick;
    logic upQ;
    logic dnQ;
  } dpStat_t;
endpackage

// File: rtl/refcomp_dp.sv
module refcomp_dp
  import refcomp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    fpdPulse,
  input  dpCtrl_t ctrl,
  output dpStat_t stat
);
  logic [RATIO_W-1:0] cnt;
  logic tick, upQ, dnQ;
  logic setUp, setDn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= ctrl.limit) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  assign setUp = upQ | tick;
  assign setDn = dnQ | fpdPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (ctrl.clearPump || (setUp && setDn)) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= setUp;
      dnQ <= setDn;
    end
  end

  assign stat.compTick = tick;
  assign stat.upQ      = upQ;
  assign stat.dnQ      = dnQ;
endmodule

// File: rtl/refcomp_ctrl.sv
module refcomp_ctrl
  import refcomp_pkg::*;
#(
  parameter int LOCK_COUNT = 8,
  parameter int WIDE_LIMIT = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ratioCode,
  input  logic              testEn,
  input  logic [2:0]        testSel,
  input  logic [3:0]        portProg,
  input  logic              fpdHalf,
  input  dpStat_t           stat,
  output dpCtrl_t           ctrl,
  output logic              pumpUp,
  output logic              pumpDn,
  output logic              lockFlag,
  output logic [3:0]        portOut,
  output logic              ratioErr
);
  localparam int LC_W  = $clog2(LOCK_COUNT + 1);
  localparam int RUN_W = $clog2(WIDE_LIMIT + 1);

  logic [1:0]         base;
  logic [2:0]         expo;
  logic [RATIO_W-1:0] ratioVal;
  logic [1:0]         forceMode;
  logic               hold;

  // ratio decode
  always_comb begin
    base     = ratioCode[4:3];
    expo     = ratioCode[2:0];
    ratioErr = 1'b0;
    if (base == 2'b00) begin
      ratioVal = RATIO_W'(2) << expo;
    end else if (expo == 3'd0) begin
      ratioVal = RATIO_W'(2);
      ratioErr = 1'b1;
    end else begin
      ratioVal = RATIO_W'({1'b0, base} + 3'd4) << (expo - 3'd1);
    end
  end

  assign forceMode      = testEn ? testSel[1:0] : 2'b00;
  assign hold           = (forceMode != 2'b00);
  assign ctrl.limit     = ratioVal - 1'b1;
  assign ctrl.clearPump = hold;

  // pulse width watch, one counter per pump direction
  logic [1:0] pulseHi;
  logic [1:0] wideNow;
  assign pulseHi = {stat.dnQ, stat.upQ};

  for (genvar g = 0; g < 2; g++) begin : gRun
    logic [RUN_W-1:0] run;
    always_ff @(posedge clk) begin
      if (!rstN) run <= '0;
      else if (!pulseHi[g] || hold) run <= '0;
      else if (run != RUN_W'(WIDE_LIMIT)) run <= run + 1'b1;
    end
    assign wideNow[g] = pulseHi[g] && (run >= RUN_W'(WIDE_LIMIT - 1));
  end

  // lock detector
  logic            wideSeen;
  logic [LC_W-1:0] goodCnt;
  logic            lockRaw;

  always_ff @(posedge clk) begin
    if (!rstN || hold) begin
      wideSeen <= 1'b0;
      goodCnt  <= '0;
      lockRaw  <= 1'b0;
    end else if (stat.compTick) begin
      wideSeen <= 1'b0;
      if (wideSeen || (|wideNow)) begin
        goodCnt <= '0;
        lockRaw <= 1'b0;
      end else begin
        if (goodCnt != LC_W'(LOCK_COUNT)) goodCnt <= goodCnt + 1'b1;
        if (goodCnt >= LC_W'(LOCK_COUNT - 1)) lockRaw <= 1'b1;
      end
    end else if (|wideNow) begin
      wideSeen <= 1'b1;
    end
  end

  // test override of pump and lock
  always_comb begin
    pumpUp   = 1'b0;
    pumpDn   = 1'b0;
    lockFlag = 1'b0;
    unique case (forceMode)
      2'b00: begin
        pumpUp   = stat.upQ;
        pumpDn   = stat.dnQ;
        lockFlag = lockRaw;
      end
      2'b01:   pumpDn   = 1'b1;
      2'b10:   pumpUp   = 1'b1;
      default: lockFlag = 1'b1;
    endcase
  end

  // port multiplexing
  always_comb begin
    if (!testEn) begin
      portOut = portProg;
    end else begin
      portOut[3:1] = testSel;
      if (!testSel[2])               portOut[0] = portProg[0];
      else if (testSel[1:0] == 2'b00) portOut[0] = fpdHalf;
      else                           portOut[0] = stat.compTick;
    end
  end
endmodule

// File: rtl/refcomp_pfd.sv
module refcomp_pfd
  import refcomp_pkg::*;
#(
  parameter int LOCK_COUNT = 8,
  parameter int WIDE_LIMIT = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fpdPulse,
  input  logic              fpdHalf,
  input  logic [CODE_W-1:0] ratioCode,
  input  logic [1:0]        pumpSel,
  input  logic              testEn,
  input  logic [2:0]        testSel,
  input  logic [3:0]        portProg,
  output logic              pumpUp,
  output logic              pumpDn,
  output logic              lockFlag,
  output logic [3:0]        portOut,
  output logic [1:0]        pumpCurrent,
  output logic              ratioErr
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  refcomp_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .fpdPulse (fpdPulse),
    .ctrl     (ctrl),
    .stat     (stat)
  );

  refcomp_ctrl #(
    .LOCK_COUNT (LOCK_COUNT),
    .WIDE_LIMIT (WIDE_LIMIT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ratioCode (ratioCode),
    .testEn    (testEn),
    .testSel   (testSel),
    .portProg  (portProg),
    .fpdHalf   (fpdHalf),
    .stat      (stat),
    .ctrl      (ctrl),
    .pumpUp    (pumpUp),
    .pumpDn    (pumpDn),
    .lockFlag  (lockFlag),
    .portOut   (portOut),
    .ratioErr  (ratioErr)
  );

  assign pumpCurrent = pumpSel;
endmodule

// File: rtl/refcomp_pfd_checks.sv
module refcomp_pfd_checks (
  input logic       clk,
  input logic       rstN,
  input logic       compTick,
  input logic       upQ,
  input logic       pumpUp,
  input logic       pumpDn,
  input logic       lockFlag,
  input logic       testEn,
  input logic [2:0] testSel
);
  assert_pump_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(pumpUp && pumpDn));

  assert_up_follows_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upQ) |-> $past(compTick));

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rstN)
    compTick |=> !compTick);

  assert_lock_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lockFlag) && !testEn && !$past(testEn)) |-> $past(compTick));

  assert_history_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(testEn) && ($past(testSel[1:0]) != 2'b00)) |-> !lockFlag);
endmodule

bind refcomp_pfd refcomp_pfd_checks u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .compTick (stat.compTick),
  .upQ      (stat.upQ),
  .pumpUp   (pumpUp),
  .pumpDn   (pumpDn),
  .lockFlag (lockFlag),
  .testEn   (testEn),
  .testSel  (testSel)
);

// File: tb/sim_refcomp_pfd.sv
module sim_refcomp_pfd;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fpdPulse = 1'b0;
  logic       fpdHalf = 1'b0;
  logic [4:0] ratioCode = 5'b00011;
  logic [1:0] pumpSel = 2'b00;
  logic       testEn = 1'b0;
  logic [2:0] testSel = 3'b000;
  logic [3:0] portProg = 4'b0000;
  logic       pumpUp, pumpDn, lockFlag, ratioErr;
  logic [3:0] portOut;
  logic [1:0] pumpCurrent;

  int nRun = 0;
  int nFail = 0;

  refcomp_pfd u0 (
    .clk(clk), .rstN(rstN), .fpdPulse(fpdPulse), .fpdHalf(fpdHalf),
    .ratioCode(ratioCode), .pumpSel(pumpSel), .testEn(testEn),
    .testSel(testSel), .portProg(portProg), .pumpUp(pumpUp),
    .pumpDn(pumpDn), .lockFlag(lockFlag), .portOut(portOut),
    .pumpCurrent(pumpCurrent), .ratioErr(ratioErr)
  );

  always #4 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expRatio(logic [4:0] c);
    if (c[4:3] == 2'b00) return 2 << c[2:0];
    if (c[2:0] == 3'd0) return 2;
    return (4 + int'(c[4:3])) << (int'(c[2:0]) - 1);
  endfunction

  function automatic int expErr(logic [4:0] c);
    return (c[4:3] != 2'b00 && c[2:0] == 3'd0) ? 1 : 0;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 reset pumpUp", int'(pumpUp), 0);
    check("R4 reset pumpDn", int'(pumpDn), 0);
    check("R5 reset lockFlag", int'(lockFlag), 0);
    rstN = 1'b1;
  endtask

  // wait for pumpUp, then answer with fpdPulse after a chosen lag
  task automatic lagRound(int lag);
    bit seen = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (pumpUp) begin seen = 1; break; end
    end
    if (!seen) check("R4 pumpUp after tick", 0, 1);
    repeat (lag - 1) @(negedge clk);
    fpdPulse = 1'b1;
    @(negedge clk);
    fpdPulse = 1'b0;
  endtask

  task automatic measure(output int per);
    bit seen = 0;
    per = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (portOut[0]) begin seen = 1; break; end
    end
    if (!seen) return;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      per++;
      if (portOut[0]) break;
    end
  endtask

  task automatic checkRatio(logic [4:0] c, string tag);
    int per;
    @(negedge clk);
    ratioCode = c;
    testEn = 1'b1;
    testSel = 3'b101;
    measure(per);
    check(tag, per, expRatio(c));
    check("R3 ratioErr flag", int'(ratioErr), expErr(c));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'd2468);

    // lock behaviour in normal mode, ratio 16
    doReset();
    lagRound(1);
    @(negedge clk);
    check("R4 simultaneous clear pumpUp", int'(pumpUp), 0);
    check("R4 simultaneous clear pumpDn", int'(pumpDn), 0);
    repeat (3) lagRound(1);
    check("R5 no lock before 8 periods", int'(lockFlag), 0);
    repeat (8) lagRound(1);
    check("R5 lock after 8 narrow periods", int'(lockFlag), 1);

    // pump-down leads: DN stays high until the next tick clears both
    fpdPulse = 1'b1;
    @(negedge clk);
    fpdPulse = 1'b0;
    check("R4 pumpDn after fpdPulse", int'(pumpDn), 1);
    check("R4 pumpUp stays low", int'(pumpUp), 0);
    begin
      bit dropped = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!pumpDn) begin dropped = 1; break; end
      end
      check("R4 tick clears pumpDn", int'(dropped), 1);
      check("R4 pumpUp low at joint clear", int'(pumpUp), 0);
      check("R5 wide pulse drops lock", int'(lockFlag), 0);
    end

    // relock, then lose lock with a 3-clock pump-up pulse
    repeat (10) lagRound(1);
    check("R5 relock", int'(lockFlag), 1);
    lagRound(3);
    lagRound(3);
    check("R5 lock lost after wide pulse", int'(lockFlag), 0);

    // test enabled with select 000 behaves normally
    @(negedge clk);
    testEn = 1'b1;
    testSel = 3'b000;
    portProg = 4'b1011;
    repeat (12) lagRound(1);
    check("R6 normal lock with testSel 000", int'(lockFlag), 1);
    check("R8 ports in test 000", int'(portOut), 4'b0001);

    // forced pump and lock modes
    @(negedge clk);
    testSel = 3'b011;
    #1;
    check("R7 x11 lockFlag", int'(lockFlag), 1);
    check("R7 x11 pumps off", int'({pumpUp, pumpDn}), 0);
    @(negedge clk);
    testSel = 3'b001;
    #1;
    check("R7 x01 pump", int'({pumpUp, pumpDn}), 1);
    check("R7 x01 lockFlag", int'(lockFlag), 0);
    @(negedge clk);
    testSel = 3'b110;
    #1;
    check("R7 x10 pump", int'({pumpUp, pumpDn}), 2);
    @(negedge clk);
    testSel = 3'b011;
    @(negedge clk);
    testEn = 1'b0;
    testSel = 3'b000;
    @(negedge clk);
    check("R7 lock history cleared", int'(lockFlag), 0);

    // directed ratio corners
    checkRatio(5'b00000, "R1 ratio code 00000");
    checkRatio(5'b00111, "R1 ratio code 00111");
    checkRatio(5'b01001, "R2 ratio code 01001");
    checkRatio(5'b11111, "R2 ratio code 11111");
    checkRatio(5'b01000, "R3 illegal 01000");
    checkRatio(5'b10000, "R3 illegal 10000");
    checkRatio(5'b11000, "R3 illegal 11000");

    // random ratio codes
    for (int k = 0; k < 12; k++) begin
      logic [4:0] c;
      c = 5'($urandom_range(0, 31));
      if (c[4:3] == 2'b00) checkRatio(c, "R1 random ratio");
      else                 checkRatio(c, "R2 random ratio");
    end

    // random port, pump override and pass-through
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      testEn   = 1'($urandom_range(0, 1));
      testSel  = 3'($urandom_range(0, 7));
      portProg = 4'($urandom_range(0, 15));
      fpdHalf  = 1'($urandom_range(0, 1));
      pumpSel  = 2'($urandom_range(0, 3));
      #1;
      check("R9 pump code pass", int'(pumpCurrent), int'(pumpSel));
      if (!testEn) begin
        check("R8 ports programmed", int'(portOut), int'(portProg));
      end else begin
        check("R8 ports follow testSel", int'(portOut[3:1]), int'(testSel));
        if (!testSel[2])
          check("R8 port0 programmed", int'(portOut[0]), int'(portProg[0]));
        else if (testSel[1:0] == 2'b00)
          check("R8 port0 fpdHalf", int'(portOut[0]), int'(fpdHalf));
        case (testSel[1:0])
          2'b01: check("R7 sink forced", int'({pumpUp, pumpDn, lockFlag}), 3'b010);
          2'b10: check("R7 source forced", int'({pumpUp, pumpDn, lockFlag}), 3'b100);
          2'b11: check("R7 disabled forced", int'({pumpUp, pumpDn, lockFlag}), 3'b001);
          default: ;
        endcase
      end
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule